// File: doc/BRIEF.md
# In-Place Accumulator/Temp Register Unsigned Divider

This block holds the two working registers of a small processor datapath, an accumulator `A` and a temporary `T`. It divides one of them by the other in place. The surrounding core writes the operands through the load ports and then pulses `start`. The divider takes `T` as the dividend and `A` as the divisor. It produces one quotient bit per clock with a restoring shift-and-subtract loop. When it finishes, the quotient goes back into `A` and the remainder into `T`.

Completion is reported by a one-cycle `done` pulse. Together with `done`, the block raises a write-enable for the zero flag. A divisor of zero is reported only through that flag. In that case the operation ends at once and neither register is altered. The block never drives any other status bit. The register contents survive reset, so a reset does not disturb operands that are already loaded.

Top module: `accDivider`

## Requirements
- R1: After a `start` accepted with `T`=dividend and `A`=divisor≠0, `aValue` becomes floor(T/A) and `tValue` becomes T mod A (e.g. T=0x5678, A=0x1234 gives A=0x0004, T=0x0DA8).
- R2: For a nonzero divisor, `busy` is high for exactly WIDTH (16) cycles starting the cycle after `start`. `done` is then high for one cycle with `busy` low, and the results are visible in that same cycle.
- R3: If `A` is zero when `start` is accepted, `done` is high in the very next cycle, `busy` never rises, and `aValue`/`tValue` keep their prior values.
- R4: On a zero divisor, `zFlag` reads 1 while `zWe` is high.
- R5: For a nonzero divisor, `zFlag` reads 1 exactly when the quotient written to `A` is zero, while `zWe` is high.
- R6: `zWe` is high only in the `done` cycle and is low at all other times.
- R7: A `start` pulse while `busy` is high is ignored: the running operation's timing and results are unchanged.
- R8: `loadA`/`loadT` while idle update the register on the next clock edge. While `busy` is high, loads are ignored.
- R9: Synchronous active-high `rst` drops `busy`, `done` and `zWe`, including mid-operation, and leaves `aValue`/`tValue` unchanged.
- R10: After a nonzero-divisor operation, the remainder in `T` is below the divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a divide (accepted when not busy) |
| loadA | input | 1 | Write `loadAData` into A |
| loadAData | input | WIDTH | Data for A |
| loadT | input | 1 | Write `loadTData` into T |
| loadTData | input | WIDTH | Data for T |
| aValue | output | WIDTH | Current A (divisor, then quotient) |
| tValue | output | WIDTH | Current T (dividend, then remainder) |
| busy | output | 1 | Iterating |
| done | output | 1 | One-cycle completion pulse |
| zFlag | output | 1 | Zero flag value to write |
| zWe | output | 1 | Zero flag write-enable |

## Verification
The bench builds the divider at its default WIDTH of 16. This makes the 0x5678 / 0x1234 case checkable as given and fixes the busy window at sixteen cycles, which the bench counts directly. Random 16-bit operands mixed with small divisors and dividends cover zero quotients, unit divisors and dividends below the divisor. Directed runs inject stray `start` and load pulses mid-operation and reset both idle and mid-division.

// File: rtl/divPkg.sv
package divPkg;
  typedef struct packed {
    logic capture;
    logic step;
    logic writeBack;
    logic zeroDiv;
  } divStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } divState_t;
endpackage

// File: rtl/divCtrl.sv
module divCtrl
  import divPkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        divisorZero,
  output divStrobes_t stb,
  output logic        busy,
  output logic        done
);
  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  divState_t state;
  logic [CW-1:0] cnt;
  logic accept;

  always_comb begin
    stb           = '0;
    accept        = start && (state != ST_RUN);
    stb.capture   = accept && !divisorZero;
    stb.zeroDiv   = accept && divisorZero;
    stb.step      = (state == ST_RUN);
    stb.writeBack = (state == ST_RUN) && (cnt == LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_RUN: begin
          if (cnt == LAST) begin
            state <= ST_DONE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (stb.capture) begin
            state <= ST_RUN;
            cnt   <= '0;
          end else if (stb.zeroDiv) begin
            state <= ST_DONE;
          end else begin
            state <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assign busy = (state == ST_RUN);
  assign done = (state == ST_DONE);

  // R2
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> !done);

  // R7
  run_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt != LAST) |=> busy);

  // R3
  zero_div_done_chk: assert property (@(posedge clk) disable iff (rst)
    stb.zeroDiv |=> (done && !busy));
endmodule

// File: rtl/divPath.sv
module divPath
  import divPkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  divStrobes_t      stb,
  input  logic             busy,
  input  logic             loadA,
  input  logic [WIDTH-1:0] loadAData,
  input  logic             loadT,
  input  logic [WIDTH-1:0] loadTData,
  output logic [WIDTH-1:0] aValue,
  output logic [WIDTH-1:0] tValue,
  output logic             divisorZero,
  output logic             zFlag
);
  logic [WIDTH-1:0] regA, regT;
  logic [WIDTH-1:0] remReg, quoReg, divReg;
  logic [WIDTH:0]   shifted, diff;
  logic [WIDTH-1:0] nextRem, nextQuo;

  always_comb begin
    shifted = {remReg, quoReg[WIDTH-1]};
    diff    = shifted - {1'b0, divReg};
    if (!diff[WIDTH]) begin
      nextRem = diff[WIDTH-1:0];
      nextQuo = {quoReg[WIDTH-2:0], 1'b1};
    end else begin
      nextRem = shifted[WIDTH-1:0];
      nextQuo = {quoReg[WIDTH-2:0], 1'b0};
    end
  end

  assign divisorZero = (regA == '0);

  // operand registers: no reset, they hold their contents
  always_ff @(posedge clk) begin
    if (stb.writeBack) begin
      regA <= nextQuo;
      regT <= nextRem;
    end else begin
      if (loadA && !busy) regA <= loadAData;
      if (loadT && !busy) regT <= loadTData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      remReg <= '0;
      quoReg <= '0;
      divReg <= '0;
      zFlag  <= 1'b0;
    end else begin
      if (stb.capture) begin
        remReg <= '0;
        quoReg <= regT;
        divReg <= regA;
      end else if (stb.step) begin
        remReg <= nextRem;
        quoReg <= nextQuo;
      end
      if (stb.zeroDiv)        zFlag <= 1'b1;
      else if (stb.writeBack) zFlag <= (nextQuo == '0);
    end
  end

  assign aValue = regA;
  assign tValue = regT;

  // R3
  zero_div_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (stb.zeroDiv && !loadA && !loadT) |=>
      (aValue == $past(aValue) && tValue == $past(tValue)));

  // R4
  zero_div_flag_chk: assert property (@(posedge clk) disable iff (rst)
    stb.zeroDiv |=> zFlag);

  // R5
  quo_zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    stb.writeBack |=> (zFlag == (aValue == '0)));

  // R10
  rem_below_div_chk: assert property (@(posedge clk) disable iff (rst)
    stb.writeBack |=> (tValue < divReg));
endmodule

// File: rtl/accDivider.sv
module accDivider
  import divPkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             loadA,
  input  logic [WIDTH-1:0] loadAData,
  input  logic             loadT,
  input  logic [WIDTH-1:0] loadTData,
  output logic [WIDTH-1:0] aValue,
  output logic [WIDTH-1:0] tValue,
  output logic             busy,
  output logic             done,
  output logic             zFlag,
  output logic             zWe
);
  divStrobes_t stb;
  logic divisorZero;

  divCtrl #(.WIDTH(WIDTH)) ctrl_i (
    .clk(clk), .rst(rst), .start(start), .divisorZero(divisorZero),
    .stb(stb), .busy(busy), .done(done)
  );

  divPath #(.WIDTH(WIDTH)) path_i (
    .clk(clk), .rst(rst), .stb(stb), .busy(busy),
    .loadA(loadA), .loadAData(loadAData),
    .loadT(loadT), .loadTData(loadTData),
    .aValue(aValue), .tValue(tValue),
    .divisorZero(divisorZero), .zFlag(zFlag)
  );

  assign zWe = done;

  // R6
  zwe_only_done_chk: assert property (@(posedge clk) disable iff (rst)
    zWe |-> (done && !busy));
endmodule

// File: tb/accDivider_tb_top.sv
module accDivider_tb_top;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, loadA = 1'b0, loadT = 1'b0;
  logic [W-1:0] loadAData = '0, loadTData = '0;
  logic [W-1:0] aValue, tValue;
  logic busy, done, zFlag, zWe;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  accDivider #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .start(start),
    .loadA(loadA), .loadAData(loadAData),
    .loadT(loadT), .loadTData(loadTData),
    .aValue(aValue), .tValue(tValue),
    .busy(busy), .done(done), .zFlag(zFlag), .zWe(zWe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] expQuo(input logic [W-1:0] t, input logic [W-1:0] a);
    return (a == 0) ? a : W'(t / a);
  endfunction

  function automatic logic [W-1:0] expRem(input logic [W-1:0] t, input logic [W-1:0] a);
    return (a == 0) ? t : W'(t % a);
  endfunction

  task automatic loadRegs(input logic [W-1:0] t, input logic [W-1:0] a);
    @(negedge clk);
    loadA = 1'b1; loadAData = a;
    loadT = 1'b1; loadTData = t;
    @(negedge clk);
    loadA = 1'b0; loadT = 1'b0;
    check("R8 load A", aValue, a);
    check("R8 load T", tValue, t);
  endtask

  // inject: 1 = stray start and load while busy
  task automatic runDiv(input logic [W-1:0] t, input logic [W-1:0] a, input bit inject);
    int n;
    loadRegs(t, a);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (a == 0) begin
      check("R3 zero-div done", done, 1);
      check("R3 zero-div busy", busy, 0);
      check("R3 A kept", aValue, a);
      check("R3 T kept", tValue, t);
      check("R4 zFlag", zFlag, 1);
      check("R6 zWe", zWe, 1);
    end else begin
      n = 0;
      while (busy && n < 40) begin
        check("R6 zWe low while busy", zWe, 0);
        n++;
        if (inject && n == 3) start = 1'b1;
        else start = 1'b0;
        if (inject && n == 7) begin
          loadA = 1'b1; loadAData = ~a;
          loadT = 1'b1; loadTData = ~t;
        end else begin
          loadA = 1'b0; loadT = 1'b0;
        end
        @(negedge clk);
      end
      start = 1'b0; loadA = 1'b0; loadT = 1'b0;
      check(inject ? "R7 busy length" : "R2 busy length", n, W);
      check("R2 done", done, 1);
      check("R2 busy low at done", busy, 0);
      check(inject ? "R7 quotient" : "R1 quotient", aValue, expQuo(t, a));
      check(inject ? "R8 remainder" : "R1 remainder", tValue, expRem(t, a));
      check("R5 zFlag", zFlag, (expQuo(t, a) == 0));
      check("R6 zWe", zWe, 1);
      checks++;
      if (!(tValue < a)) begin
        errors++;
        $display("FAIL R10 actual=0x%0h expected below 0x%0h", tValue, a);
      end
    end
    @(negedge clk);
    check("R2 done pulse ends", done, 0);
    check("R6 zWe ends", zWe, 0);
  endtask

  task automatic finishRun();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R2 actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9 reset busy", busy, 0);
    check("R9 reset done", done, 0);
    check("R9 reset zWe", zWe, 0);

    // R1 stated example
    runDiv(16'h5678, 16'h1234, 0);
    // R3 R4 divide by zero
    runDiv(16'hBEEF, 16'h0000, 0);
    // R5 zero quotient
    runDiv(16'h0003, 16'h0009, 0);
    runDiv(16'h0000, 16'h0001, 0);
    runDiv(16'hFFFF, 16'h0001, 0);
    runDiv(16'hFFFF, 16'hFFFF, 0);
    runDiv(16'h8000, 16'h0003, 0);
    // R7 R8 stray start/load while busy
    runDiv(16'h5678, 16'h1234, 1);
    runDiv(16'hA5A5, 16'h0007, 1);

    // R9 reset while idle keeps A/T
    loadRegs(16'h2222, 16'h1111);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R9 A kept over reset", aValue, 16'h1111);
    check("R9 T kept over reset", tValue, 16'h2222);

    // R9 reset mid-operation
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 busy before reset", busy, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9 busy after reset", busy, 0);
    check("R9 done after reset", done, 0);
    check("R9 A after mid reset", aValue, 16'h1111);
    check("R9 T after mid reset", tValue, 16'h2222);
    repeat (20) @(negedge clk);
    check("R9 stays idle", busy, 0);

    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] rt, ra;
      rt = W'($urandom);
      ra = W'($urandom);
      case ($urandom % 6)
        0: ra = W'($urandom % 8);
        1: rt = W'($urandom % 16);
        2: ra = 16'h0000;
        default: ;
      endcase
      runDiv(rt, ra, (i % 10) == 0);
    end

    finishRun();
  end
endmodule